// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block holds the pin control state for one bank of 32 general-purpose pins, grouped as four ports of eight pins. For every port it keeps a mode-enable register (the pin belongs to the GPIO function), a drive-enable register and a drive-value register. It also keeps a read-only register with the synchronized pad level. All of these sit on a small 32-bit register bus with an address, a write strobe, write data and registered read data.

Each writable register has a second address, the masked alias. A write there changes only the bits that the upper byte of the write data selects. Software can therefore flip one pin without reading the register first, and two agents that own different pins of the same port cannot undo each other's changes. The pad side gives 32 drive values and 32 drive enables. A pin drives its pad only when it is both in GPIO mode and drive-enabled.

Top module: `gpiomw_bank`

## Requirements
- R1: Synchronous active-high reset clears every mode, drive-enable and drive-value register to 0. With all registers at 0, `pad_oe` is 0, `pad_out` is 0 and `bus_rdata` is 0.
- R2: Plain byte addresses: group base plus 4 × port. The group bases are mode 0x000, drive-enable 0x010, drive-value 0x020 and pad level 0x030. A plain write loads wdata[7:0] into the addressed register. `bus_rdata` shows the addressed register one clock after the address is presented.
- R3: Reads return the last value written to the mode, drive-enable and drive-value registers in bits 7:0, and 0 in bits 31:8. Write data bits 31:8 have no effect on a plain write.
- R4: The masked alias of each register is its plain address plus 0x080. A write there sets register bit n to wdata[n] only where wdata[n+8] is 1. All other bits keep their value. A read at an alias address returns the same register as the plain address.
- R5: A masked write whose wdata[15:8] is all zero leaves the register unchanged.
- R6: `pad_oe[i]` equals mode bit i AND drive-enable bit i, one clock after the registers change. `pad_out[i]` equals drive-value bit i. Pin i is port i/8, bit i%8.
- R7: A level on `pad_in` held for at least 4 clocks is returned by a read of the pad-level register, with pin i in bit i%8 of port i/8.
- R8: Writes to the pad-level register (plain or masked) and to addresses outside both windows change nothing. Reads of addresses outside both windows return 0.
- R9: A write to one port leaves the registers of the other ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe, one write per high clock |
| bus_wdata | input | 32 | Write data; bits 15:8 are the select byte for aliases |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Drive values |
| pad_oe | output | 32 | Drive enables |

## Verification
The masked-write path is tried with several select bytes: a low nibble, a single high bit, all eight bits and none. Together these separate a correct merge from an alias that acts as a plain write, from one that ignores the select byte, and from one that inverts it. Plain writes with junk in the upper bits show whether bits 31:8 are really dropped. Writes aimed at the pad-level register and at unmapped addresses show that neither path leaks into state. Overlapping mode and drive-enable patterns on the pad side tell an AND gate apart from either register alone. A distinct byte per port on `pad_in` catches swapped port order.

// File: rtl/gpiomw_pkg.sv
package gpiomw_pkg;
  typedef enum logic [1:0] {
    GRP_MODE  = 2'd0,
    GRP_DRVEN = 2'd1,
    GRP_DRVAL = 2'd2,
    GRP_LEVEL = 2'd3
  } grp_e;

  typedef struct packed {
    logic       hit;
    logic       masked;
    grp_e       grp;
    logic [1:0] port;
  } dec_t;

  localparam int unsigned GROUP_STRIDE = 16;
  localparam int unsigned PORT_STRIDE  = 4;
  localparam int unsigned WINDOW_BYTES = 4 * GROUP_STRIDE;
endpackage

// File: rtl/gpiomw_addr_dec.sv
module gpiomw_addr_dec
  import gpiomw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned PORTS    = 4,
  parameter logic [11:0] MASK_OFS = 12'h080
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] WIN  = ADDR_W'(WINDOW_BYTES);
  localparam logic [ADDR_W-1:0] MOFS = ADDR_W'(MASK_OFS);

  logic [ADDR_W-1:0] off;
  logic              in_plain;
  logic              in_mask;

  always_comb begin
    in_plain = (addr < WIN);
    in_mask  = (addr >= MOFS) && (addr < MOFS + WIN);
    off      = in_mask ? (addr - MOFS) : addr;
    dec.masked = in_mask;
    dec.grp    = grp_e'(off[5:4]);
    dec.port   = off[3:2];
    dec.hit    = (in_plain || in_mask) && (int'(off[3:2]) < int'(PORTS));
  end
endmodule

// File: rtl/gpiomw_sync.sv
module gpiomw_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpiomw_port.sv
module gpiomw_port
  import gpiomw_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               masked,
  input  grp_e               grp,
  input  logic [2*PIN_W-1:0] wdata,
  output logic [PIN_W-1:0]   mode_q,
  output logic [PIN_W-1:0]   drven_q,
  output logic [PIN_W-1:0]   drval_q
);
  logic [PIN_W-1:0] dat;
  logic [PIN_W-1:0] sel;

  assign dat = wdata[PIN_W-1:0];
  assign sel = masked ? wdata[2*PIN_W-1:PIN_W] : '1;

  function automatic logic [PIN_W-1:0] merge(input logic [PIN_W-1:0] cur,
                                             input logic [PIN_W-1:0] nd,
                                             input logic [PIN_W-1:0] m);
    return (cur & ~m) | (nd & m);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      drven_q <= '0;
      drval_q <= '0;
    end else if (wr) begin
      case (grp)
        GRP_MODE:  mode_q  <= merge(mode_q, dat, sel);
        GRP_DRVEN: drven_q <= merge(drven_q, dat, sel);
        GRP_DRVAL: drval_q <= merge(drval_q, dat, sel);
        default: ;
      endcase
    end
  end

  AST_PLAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr && !masked && grp == GRP_DRVAL) |=> drval_q == $past(wdata[PIN_W-1:0])); // R2

  AST_MASK_SEL: assert property (@(posedge clk) disable iff (rst)
    (wr && masked && grp == GRP_MODE) |=>
      (((mode_q ^ $past(mode_q)) & ~$past(wdata[2*PIN_W-1:PIN_W])) == '0)); // R4

  AST_MASK_NOSEL: assert property (@(posedge clk) disable iff (rst)
    (wr && masked && wdata[2*PIN_W-1:PIN_W] == '0) |=>
      ($stable(mode_q) && $stable(drven_q) && $stable(drval_q))); // R5

  AST_LEVEL_RO: assert property (@(posedge clk) disable iff (rst)
    (!wr || grp == GRP_LEVEL) |=>
      ($stable(mode_q) && $stable(drven_q) && $stable(drval_q))); // R8
endmodule

// File: rtl/gpiomw_bank.sv
module gpiomw_bank
  import gpiomw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned PORTS    = 4,
  parameter int unsigned PIN_W    = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [11:0] MASK_OFS = 12'h080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PORTS*PIN_W-1:0] pad_in,
  output logic [PORTS*PIN_W-1:0] pad_out,
  output logic [PORTS*PIN_W-1:0] pad_oe
);
  localparam int unsigned PINS = PORTS * PIN_W;

  dec_t dec;
  logic [PINS-1:0]  pad_sync;
  logic [PINS-1:0]  level_q;
  logic [PIN_W-1:0] mode_a  [PORTS];
  logic [PIN_W-1:0] drven_a [PORTS];
  logic [PIN_W-1:0] drval_a [PORTS];
  logic [PINS-1:0]  mode_all;
  logic [PINS-1:0]  drven_all;
  logic [PINS-1:0]  drval_all;
  logic [PIN_W-1:0] rd_sel;

  gpiomw_addr_dec #(.ADDR_W(ADDR_W), .PORTS(PORTS), .MASK_OFS(MASK_OFS)) dec_i (
    .addr(bus_addr), .dec(dec));

  gpiomw_sync #(.W(PINS)) sync_i (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_sync));

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= pad_sync;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpiomw_port #(.PIN_W(PIN_W)) port_i (
      .clk    (clk),
      .rst    (rst),
      .wr     (bus_wr && dec.hit && int'(dec.port) == p),
      .masked (dec.masked),
      .grp    (dec.grp),
      .wdata  (bus_wdata[2*PIN_W-1:0]),
      .mode_q (mode_a[p]),
      .drven_q(drven_a[p]),
      .drval_q(drval_a[p])
    );
    assign mode_all [p*PIN_W +: PIN_W] = mode_a[p];
    assign drven_all[p*PIN_W +: PIN_W] = drven_a[p];
    assign drval_all[p*PIN_W +: PIN_W] = drval_a[p];
  end

  always_comb begin
    rd_sel = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (dec.hit && int'(dec.port) == p) begin
        case (dec.grp)
          GRP_MODE:  rd_sel = mode_a[p];
          GRP_DRVEN: rd_sel = drven_a[p];
          GRP_DRVAL: rd_sel = drval_a[p];
          default:   rd_sel = level_q[p*PIN_W +: PIN_W];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pad_oe    <= '0;
    end else begin
      bus_rdata <= DATA_W'(rd_sel);
      pad_oe    <= mode_all & drven_all;
    end
  end

  assign pad_out = drval_all;

  AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
    pad_oe == $past(mode_all & drven_all)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dec.hit |=> bus_rdata == '0); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0)); // R1
endmodule

// File: tb/gpiomw_bank_tb_top.sv
module gpiomw_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  localparam logic [11:0] V_WADDR [NV] = '{
    12'h020, 12'h0A0, 12'h0A0, 12'h0A0, 12'h014, 12'h094,
    12'h00C, 12'h08C, 12'h02C, 12'h030, 12'h0B0, 12'h040};
  localparam logic [31:0] V_WDATA [NV] = '{
    32'hFFFF_FFA5, 32'h0000_0F03, 32'h0000_00FF, 32'h0000_8000, 32'h0000_003C, 32'h0000_0101,
    32'h0000_0081, 32'h0000_FF00, 32'h0000_005A, 32'h0000_00FF, 32'h0000_FFFF, 32'h0000_0077};
  localparam logic [11:0] V_RADDR [NV] = '{
    12'h020, 12'h0A0, 12'h020, 12'h020, 12'h014, 12'h014,
    12'h00C, 12'h00C, 12'h020, 12'h030, 12'h030, 12'h040};
  localparam logic [31:0] V_EXP [NV] = '{
    32'h0000_00A5, 32'h0000_00A3, 32'h0000_00A3, 32'h0000_0023, 32'h0000_003C, 32'h0000_003D,
    32'h0000_0081, 32'h0000_0000, 32'h0000_0023, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000};
  localparam string V_REQ [NV] = '{
    "R3", "R4", "R5", "R4", "R2", "R4", "R2", "R4", "R9", "R8", "R8", "R8"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpiomw_bank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    rd(12'h004, v); check("R1 mode p1", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(V_WADDR[i], V_WDATA[i]);
      rd(V_RADDR[i], v);
      check(V_REQ[i], v, V_EXP[i]);
    end

    // R6 pad gating: mode p0 = F0, drive-enable p0 = 3C -> 30
    wr(12'h000, 32'h0000_00F0);
    wr(12'h010, 32'h0000_003C);
    @(negedge clk);
    check("R6 pad_oe", pad_oe, 32'h0000_0030);
    check("R6 pad_out", pad_out, 32'h5A00_0023);

    // R7 pad level per port
    pad_in = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rd(12'h030, v); check("R7 p0", v, 32'h78);
    rd(12'h034, v); check("R7 p1", v, 32'h56);
    rd(12'h038, v); check("R7 p2", v, 32'h34);
    rd(12'h0BC, v); check("R7 alias p3", v, 32'h12);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 pad_out after reset", pad_out, 32'h0);
    rd(12'h010, v); check("R1 drive-enable after reset", v, 32'h0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=running exp=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule